// File: doc/BRIEF.md
# Delayed-Request Discard Timer Unit

This block sits beside the delayed-transaction queues of a two-sided bus bridge. It watches how long a queued delayed request waits for its initiator to come back. There is one countdown per side. The queue logic pulses a start strobe when it parks a delayed request for a side, and a completion strobe when the initiator retries and finishes it. If the countdown runs out first, the block emits a one-cycle discard pulse for that side, so the queue can drop the stale entry.

Each side can pick a long wait of 2^LONG_LOG2 clocks or a short wait of 2^SHORT_LOG2 clocks. The defaults are 2^15 and 2^10. The choice is made through one 32-bit control/status word. That word also holds a sticky expiry flag, which is cleared by writing 1 to it. It also holds an enable that lets any expiry pull an active-low system-error line on the primary side low for one clock.

Top module: `dtx_discard_unit`

## Requirements
- R1: After synchronous reset, the register reads 0x00000000, `serr_n_o` is 1 and `discard_o` is 0.
- R2: Register bit 24 picks the primary length: 0 means 2^LONG_LOG2 clocks and 1 means 2^SHORT_LOG2 clocks. If `start_i[0]` is sampled at edge k, `discard_o[0]` rises at edge k+N.
- R3: Register bit 25 picks the secondary length in the same way, for `start_i[1]` and `discard_o[1]`.
- R4: A completion strobe sampled at any edge up to and including the expiry edge stops the timer. It causes no discard, no status change and no system error.
- R5: Register bit 26 becomes 1 on any expiry and holds its value. Writing 1 to it clears it, and writing 0 leaves it alone. An expiry in the same cycle as a clearing write leaves the bit at 1.
- R6: When bit 27 is 1, each expiry drives `serr_n_o` low for the single cycle in which `discard_o` is high. When bit 27 is 0, `serr_n_o` stays 1.
- R7: If both sides expire in the same cycle, both `discard_o` bits rise together and `serr_n_o` is low for just one cycle.
- R8: Bits 31:28 and 23:0 always read 0, and writes to them have no effect.
- R9: Changing a length bit while its timer runs does not alter the pending expiry. The new length applies from the next start.
- R10: A start strobe on a running timer reloads the full length, counted from that new strobe.
- R11: Every discard pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 2 | Delayed request queued; bit 0 primary, bit 1 secondary |
| done_i | input | 2 | Delayed request completed by retry; per side |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Current register value |
| discard_o | output | 2 | One-cycle drop request per side |
| serr_n_o | output | 1 | Active-low system error toward the primary side |

## Verification
A countdown that is off by even one state shows up as a discard edge one clock early or late. The latency sweep measures that edge to the exact cycle for both sides and both lengths, and also with restarts and mid-run length changes. A cancellation that fails to stop a timer leaves a stray discard pulse and sets the sticky bit within N clocks of the strobe, so the bench sweeps cancellation over every cycle of the short window. A flaw in the flag logic or the error gating shows on `reg_rdata_o` and `serr_n_o` in the very cycle of expiry, or at the next write.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

    localparam int NSIDES   = 2;
    localparam int SIDE_PRI = 0;
    localparam int SIDE_SEC = 1;

    // bit positions inside the 32-bit control/status word
    localparam int SEL_LSB  = 24;
    localparam int STAT_BIT = 26;
    localparam int EN_BIT   = 27;

    typedef struct packed {
        logic              serr_en;    // bit 27
        logic              sticky;     // bit 26
        logic [NSIDES-1:0] short_sel;  // bits 25:24, [0] primary
    } ctrl_t;

    function automatic logic [31:0] pack_word(input ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[SEL_LSB +: NSIDES] = c.short_sel;
        w[STAT_BIT]          = c.sticky;
        w[EN_BIT]            = c.serr_en;
        return w;
    endfunction

endpackage

// File: rtl/dtx_side_timer.sv
module dtx_side_timer #(
    parameter int LONG_LOG2  = 15,
    parameter int SHORT_LOG2 = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic done_i,
    input  logic short_i,
    output logic expire_o,
    output logic discard_o
);
    localparam int CW = LONG_LOG2;
    localparam logic [CW-1:0] LONG_LAST  = {CW{1'b1}};
    localparam logic [CW-1:0] SHORT_LAST = CW'((64'd1 << SHORT_LOG2) - 64'd1);

    logic          running;
    logic [CW-1:0] cnt;

    // completion and restart both take precedence over an expiry
    assign expire_o = running && !start_i && !done_i && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            cnt       <= '0;
            discard_o <= 1'b0;
        end else begin
            discard_o <= expire_o;
            if (start_i) begin
                running <= 1'b1;
                cnt     <= short_i ? SHORT_LAST : LONG_LAST;
            end else if (done_i || expire_o) begin
                running <= 1'b0;
            end else if (running) begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/dtx_ctrl_reg.sv
module dtx_ctrl_reg
    import dtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [31:0]       wdata_i,
    input  logic [NSIDES-1:0] expire_i,
    output ctrl_t             ctrl_o,
    output logic [31:0]       rdata_o
);
    ctrl_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (wr_i) begin
                q.short_sel <= wdata_i[SEL_LSB +: NSIDES];
                q.serr_en   <= wdata_i[EN_BIT];
            end
            if (|expire_i)
                q.sticky <= 1'b1;
            else if (wr_i && wdata_i[STAT_BIT])
                q.sticky <= 1'b0;
        end
    end

    assign ctrl_o  = q;
    assign rdata_o = pack_word(q);
endmodule

// File: rtl/dtx_serr_gen.sv
module dtx_serr_gen
    import dtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [NSIDES-1:0] expire_i,
    output logic              serr_n_o
);
    always_ff @(posedge clk) begin
        if (rst) serr_n_o <= 1'b1;
        else     serr_n_o <= ~(en_i & (|expire_i));
    end
endmodule

// File: rtl/dtx_discard_unit.sv
module dtx_discard_unit
    import dtx_pkg::*;
#(
    parameter int LONG_LOG2  = 15,
    parameter int SHORT_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSIDES-1:0] start_i,
    input  logic [NSIDES-1:0] done_i,
    input  logic              reg_wr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic [NSIDES-1:0] discard_o,
    output logic              serr_n_o
);
    ctrl_t             ctrl;
    logic [NSIDES-1:0] expire;

    for (genvar s = 0; s < NSIDES; s++) begin : g_side
        dtx_side_timer #(
            .LONG_LOG2 (LONG_LOG2),
            .SHORT_LOG2(SHORT_LOG2)
        ) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .start_i  (start_i[s]),
            .done_i   (done_i[s]),
            .short_i  (ctrl.short_sel[s]),
            .expire_o (expire[s]),
            .discard_o(discard_o[s])
        );
    end

    dtx_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .expire_i(expire),
        .ctrl_o  (ctrl),
        .rdata_o (reg_rdata_o)
    );

    dtx_serr_gen u_serr (
        .clk     (clk),
        .rst     (rst),
        .en_i    (ctrl.serr_en),
        .expire_i(expire),
        .serr_n_o(serr_n_o)
    );
endmodule

// File: rtl/dtx_discard_chk.sv
module dtx_discard_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  start_i,
    input logic [1:0]  done_i,
    input logic        reg_wr_i,
    input logic [31:0] reg_wdata_i,
    input logic [31:0] reg_rdata_o,
    input logic [1:0]  discard_o,
    input logic        serr_n_o
);
    p_pri_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        discard_o[0] |=> !discard_o[0]);
    p_sec_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        discard_o[1] |=> !discard_o[1]);
    p_pri_done_r4: assert property (@(posedge clk) disable iff (rst)
        done_i[0] |=> !discard_o[0]);
    p_sec_done_r4: assert property (@(posedge clk) disable iff (rst)
        done_i[1] |=> !discard_o[1]);
    p_restart_r10: assert property (@(posedge clk) disable iff (rst)
        (start_i != 2'b00) |=> ((discard_o & $past(start_i)) == 2'b00));
    p_serr_with_discard_r6: assert property (@(posedge clk) disable iff (rst)
        !serr_n_o |-> (discard_o != 2'b00));
    p_serr_gated_r6: assert property (@(posedge clk) disable iff (rst)
        !serr_n_o |-> $past(reg_rdata_o[27]));
    p_status_set_r5: assert property (@(posedge clk) disable iff (rst)
        (discard_o != 2'b00) |-> reg_rdata_o[26]);
    p_status_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_rdata_o[26]) && !$past(reg_wr_i && reg_wdata_i[26])) |-> reg_rdata_o[26]);
endmodule

bind dtx_discard_unit dtx_discard_chk u_chk (.*);

// File: tb/tb_dtx_discard_unit.sv
module tb_dtx_discard_unit;
    localparam int LL = 6;
    localparam int SL = 3;
    localparam int NLONG  = 1 << LL;
    localparam int NSHORT = 1 << SL;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  start_i = '0;
    logic [1:0]  done_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [1:0]  discard_o;
    logic        serr_n_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dtx_discard_unit #(.LONG_LOG2(LL), .SHORT_LOG2(SL)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .done_i(done_i),
        .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .discard_o(discard_o), .serr_n_o(serr_n_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input logic en, input logic clr,
                                         input logic s1, input logic s0);
        return {4'b0, en, clr, s1, s0, 24'b0};
    endfunction

    task automatic wreg(input logic [31:0] v);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_wdata_i = v;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    // start at n0; restart/cancel/write driven at negedge j (sampled at edge k+j)
    task automatic run(input logic [1:0] smask, input int restart_at, input int cancel_at,
                       input int wr_at, input logic [31:0] wr_val, input int limit,
                       output int first_j, output int hi, output int serr_cnt,
                       output int both);
        first_j = 0; hi = 0; serr_cnt = 0; both = 0;
        @(negedge clk);
        start_i = smask;
        for (int j = 1; j <= limit; j++) begin
            @(negedge clk);
            if (discard_o != 2'b00) begin
                if (first_j == 0) first_j = j;
                hi++;
            end
            if (discard_o == 2'b11) both++;
            if (!serr_n_o) serr_cnt++;
            start_i     = (j == restart_at) ? smask : 2'b00;
            done_i      = (j == cancel_at)  ? smask : 2'b00;
            reg_wr_i    = (j == wr_at);
            reg_wdata_i = (j == wr_at) ? wr_val : 32'h0;
        end
        start_i = '0; done_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int fj, hi, sc, bo, n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rdata", reg_rdata_o, 0);
        chk("R1 serr_n", serr_n_o, 1);
        chk("R1 discard", discard_o, 0);

        // R8: reserved bits ignore writes; R5: W1C on a clear flag keeps it 0
        wreg(32'hFFFF_FFFF);
        chk("R8 reserved/readback", reg_rdata_o, 32'h0B00_0000);
        wreg(32'h0);
        chk("R8 readback zero", reg_rdata_o, 0);

        // R2/R3/R6/R11 sweep over side, length and enable
        for (int side = 0; side < 2; side++)
            for (int sel = 0; sel < 2; sel++)
                for (int en = 0; en < 2; en++) begin
                    n = sel ? NSHORT : NLONG;
                    wreg(word(en[0], 1'b0, sel[0], sel[0]));
                    run(side ? 2'b10 : 2'b01, 0, 0, 0, 0, n + 4, fj, hi, sc, bo);
                    chk(side ? "R3 latency" : "R2 latency", fj, n + 1);
                    chk("R11 pulse width", hi, 1);
                    chk("R6 serr count", sc, en);
                    chk("R5 status set", reg_rdata_o[26], 1);
                    wreg(word(en[0], 1'b0, sel[0], sel[0]));
                    chk("R5 write 0 keeps", reg_rdata_o[26], 1);
                    wreg(word(en[0], 1'b1, sel[0], sel[0]));
                    chk("R5 write 1 clears", reg_rdata_o[26], 0);
                end

        // R4: cancel at every cycle of the short window, both sides
        wreg(word(1'b1, 1'b0, 1'b1, 1'b1));
        for (int side = 0; side < 2; side++)
            for (int d = 1; d <= NSHORT; d++) begin
                run(side ? 2'b10 : 2'b01, 0, d, 0, 0, NSHORT + 4, fj, hi, sc, bo);
                chk("R4 no discard", hi, 0);
                chk("R4 no serr", sc, 0);
                chk("R4 status clear", reg_rdata_o[26], 0);
            end
        wreg(word(1'b1, 1'b0, 1'b0, 1'b0));
        for (int d = 1; d <= NLONG; d += 31) begin
            run(2'b01, 0, d, 0, 0, NLONG + 4, fj, hi, sc, bo);
            chk("R4 long no discard", hi, 0);
        end

        // R7: both sides expire together
        wreg(word(1'b1, 1'b1, 1'b1, 1'b1));
        run(2'b11, 0, 0, 0, 0, NSHORT + 4, fj, hi, sc, bo);
        chk("R7 latency", fj, NSHORT + 1);
        chk("R7 both together", bo, 1);
        chk("R7 single serr", sc, 1);

        // R9: mid-run length change
        wreg(word(1'b1, 1'b1, 1'b0, 1'b0));
        run(2'b01, 0, 0, 5, word(1'b1, 1'b0, 1'b1, 1'b1), NLONG + 4, fj, hi, sc, bo);
        chk("R9 old length kept", fj, NLONG + 1);
        chk("R9 new select stored", reg_rdata_o[25:24], 3);
        run(2'b01, 0, 0, 0, 0, NSHORT + 4, fj, hi, sc, bo);
        chk("R9 new length next start", fj, NSHORT + 1);

        // R10: restart while running
        wreg(word(1'b1, 1'b1, 1'b1, 1'b1));
        run(2'b10, 5, 0, 0, 0, NSHORT + 10, fj, hi, sc, bo);
        chk("R10 restart latency", fj, NSHORT + 6);
        chk("R10 single pulse", hi, 1);

        // R5: clear and expiry on the same edge -> stays set
        wreg(word(1'b1, 1'b1, 1'b1, 1'b1));
        run(2'b01, 0, 0, NSHORT, word(1'b1, 1'b1, 1'b1, 1'b1), NSHORT + 4, fj, hi, sc, bo);
        chk("R5 set beats clear", reg_rdata_o[26], 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule